// File: doc/BRIEF.md
# Bus Ownership Handoff Handshake

This block passes control of a shared bus between its default owner and one alternate master. Three active-low wires carry the handshake: a request from the alternate master, a grant from the owner, and a grant-acknowledge by which the alternate master claims the bus. The owner side runs its own simple bus cycles. It answers a request with a grant only between cycles. It takes its strobe and data drivers off the bus while the bus is claimed.

The requester side raises the request when its internal transfer is pending. It claims the bus once the grant is present and the bus is quiet. It keeps the bus while the transfer stays pending. The bus-level grant-acknowledge is the wired-AND of the requester's own line and an acknowledge from any other master. When the owner's drivers are off, the bus strobe reads as pulled high.

Top module: `bus_handoff`

## Requirements
- R1: While rst_ni is low, br_n_o, bg_n_o, bgack_n_o and as_n_o are 1 and own_oe_o is 1.
- R2: When xfer_pend_i is 1 with the requester idle, br_n_o goes to 0 after the next clock edge. If the owner is idle at an edge where it sees br_n_o at 0, bg_n_o goes to 0 after that edge.
- R3: The grant is issued only between owner cycles. A request that arrives while as_n_o is 0 is answered one edge after the owner's cycle ends.
- R4: The requester drives its grant-acknowledge to 0 only after an edge at which all four of these hold together: bg_n_o is 0, the bus strobe is 1, dack_n_i is 1 and bgack_n_o is 1. If dack_n_i or ext_back_n_i is 0, it keeps waiting.
- R5: If bg_n_o and bgack_n_o are both 0 at an edge, own_oe_o is 0 after that edge.
- R6: br_n_o returns to 1 one edge after the requester has driven its grant-acknowledge to 0. The owner returns bg_n_o to 1 one edge after it sees br_n_o at 1.
- R7: The requester holds bgack_n_o at 0 while xfer_pend_i stays 1. When xfer_pend_i is seen at 0, bgack_n_o returns to 1 after that edge. own_oe_o returns to 1 one edge after the owner sees bgack_n_o at 1.
- R8: In the idle owner state, with no request seen, own_go_i at 1 starts a cycle, and as_n_o is 0 after that edge. as_n_o stays at 0 until an edge sees dack_n_i at 0, and returns to 1 after that edge. own_go_i has no effect while the bus is held.
- R9: If the request is withdrawn before the claim, the owner sees br_n_o at 1 while granting and returns bg_n_o to 1 after that edge, leaving own_oe_o at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| own_go_i | input | 1 | The owner wants to start a bus cycle |
| dack_n_i | input | 1 | Data transfer acknowledge from memory, active low |
| xfer_pend_i | input | 1 | The requester's internal transfer is pending |
| ext_back_n_i | input | 1 | Grant-acknowledge from another master, active low |
| br_n_o | output | 1 | Bus request, active low |
| bg_n_o | output | 1 | Bus grant, active low |
| bgack_n_o | output | 1 | Bus-level grant-acknowledge, active low |
| as_n_o | output | 1 | Bus address strobe, reads 1 while the owner's drivers are off |
| own_oe_o | output | 1 | The owner's address, data and strobe drivers are enabled |

## Verification
Every output is decoded from state, so each result is due one edge after the stimulus that causes it. Inputs are applied at a falling edge and outputs are checked at the next falling edge. A full handoff therefore shows one edge for each step: request, grant, claim, driver float with request release, and grant release. Release of the bus takes two edges: first the acknowledge rises, then the drivers come back on. The vector table holds the expected outputs for each edge in turn, so a step that comes one edge early or late shows up at once.

// File: rtl/bh_pkg.sv
package bh_pkg;
  typedef enum logic [2:0] {
    O_IDLE, O_CYCLE, O_GRANT, O_HELD_G, O_HELD
  } own_state_e;

  typedef enum logic [1:0] {
    R_IDLE, R_REQ, R_CLAIM, R_OWN
  } req_state_e;
endpackage

// File: rtl/bh_owner.sv
module bh_owner
  import bh_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  input  logic dack_n_i,
  input  logic br_n_i,
  input  logic back_n_i,
  output logic bg_n_o,
  output logic as_n_o,
  output logic oe_o
);
  own_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      O_IDLE:   if (!br_n_i) state_d = O_GRANT;       // request beats a new cycle
                else if (go_i) state_d = O_CYCLE;
      O_CYCLE:  if (!dack_n_i) state_d = O_IDLE;
      O_GRANT:  if (!back_n_i) state_d = O_HELD_G;
                else if (br_n_i) state_d = O_IDLE;    // withdrawn request
      O_HELD_G: if (br_n_i) state_d = O_HELD;
      O_HELD:   if (back_n_i) state_d = O_IDLE;
      default:  state_d = O_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) state_q <= O_IDLE;
    else         state_q <= state_d;

  assign bg_n_o = !(state_q == O_GRANT || state_q == O_HELD_G);
  assign as_n_o = !(state_q == O_CYCLE);
  assign oe_o   = !(state_q == O_HELD_G || state_q == O_HELD);

  AST_GRANT_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bg_n_o) |-> $past(as_n_o));                                 // R3
  AST_FLOAT_WHEN_CLAIMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bg_n_o && !back_n_i) |=> !oe_o);                                // R5
  AST_GRANT_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bg_n_o) |-> $past(br_n_i));                                 // R6
  AST_RESUME_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_o) |-> $past(back_n_i));                                 // R7
  AST_STROBE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!as_n_o && dack_n_i) |=> !as_n_o);                               // R8
endmodule

// File: rtl/bh_requester.sv
module bh_requester
  import bh_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pend_i,
  input  logic bg_n_i,
  input  logic as_n_i,
  input  logic dack_n_i,
  input  logic bus_back_n_i,
  output logic br_n_o,
  output logic back_n_o
);
  req_state_e state_q, state_d;
  logic bus_free;

  assign bus_free = !bg_n_i && as_n_i && dack_n_i && bus_back_n_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      R_IDLE:  if (pend_i) state_d = R_REQ;
      R_REQ:   if (!pend_i) state_d = R_IDLE;
               else if (bus_free) state_d = R_CLAIM;
      R_CLAIM: state_d = R_OWN;
      R_OWN:   if (!pend_i) state_d = R_IDLE;
      default: state_d = R_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) state_q <= R_IDLE;
    else         state_q <= state_d;

  assign br_n_o   = !(state_q == R_REQ || state_q == R_CLAIM);
  assign back_n_o = !(state_q == R_CLAIM || state_q == R_OWN);

  AST_CLAIM_COND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(back_n_o) |-> $past(!bg_n_i && as_n_i && dack_n_i && bus_back_n_i)); // R4
  AST_REQ_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(br_n_o) |-> ($past(!back_n_o) || $past(!pend_i)));                   // R6
  AST_HOLD_WHILE_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!back_n_o && pend_i) |=> !back_n_o);                                       // R7
endmodule

// File: rtl/bus_handoff.sv
module bus_handoff (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic own_go_i,
  input  logic dack_n_i,
  input  logic xfer_pend_i,
  input  logic ext_back_n_i,
  output logic br_n_o,
  output logic bg_n_o,
  output logic bgack_n_o,
  output logic as_n_o,
  output logic own_oe_o
);
  logic req_back_n, own_as_n, own_oe;

  assign bgack_n_o = req_back_n & ext_back_n_i;  // wired-AND
  assign as_n_o    = own_oe ? own_as_n : 1'b1;   // pulled up when floated
  assign own_oe_o  = own_oe;

  bh_owner u_owner (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .go_i     (own_go_i),
    .dack_n_i (dack_n_i),
    .br_n_i   (br_n_o),
    .back_n_i (bgack_n_o),
    .bg_n_o   (bg_n_o),
    .as_n_o   (own_as_n),
    .oe_o     (own_oe)
  );

  bh_requester u_req (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pend_i       (xfer_pend_i),
    .bg_n_i       (bg_n_o),
    .as_n_i       (as_n_o),
    .dack_n_i     (dack_n_i),
    .bus_back_n_i (bgack_n_o),
    .br_n_o       (br_n_o),
    .back_n_o     (req_back_n)
  );
endmodule

// File: tb/bus_handoff_tb_top.sv
module bus_handoff_tb_top;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic own_go = 1'b0, dack_n = 1'b1, pend = 1'b0, ext_n = 1'b1;
  logic br_n, bg_n, back_n, as_n, oe;
  int n_tests = 0, n_fail = 0;

  always #4 clk = ~clk;

  bus_handoff dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .own_go_i(own_go), .dack_n_i(dack_n),
    .xfer_pend_i(pend), .ext_back_n_i(ext_n), .br_n_o(br_n), .bg_n_o(bg_n),
    .bgack_n_o(back_n), .as_n_o(as_n), .own_oe_o(oe)
  );

  // {go, dack_n, pend, ext_n, | br, bg, back, as, oe}
  localparam int NV = 27;
  localparam logic [8:0] VEC [NV] = '{
    9'b0111_01111, // 0  R2 request
    9'b0111_00111, // 1  R2 grant
    9'b0111_00011, // 2  R4 claim
    9'b0111_10010, // 3  R5 float, R6 request released
    9'b0111_11010, // 4  R6 grant released
    9'b1111_11010, // 5  R8 go ignored while held
    9'b0101_11110, // 6  R7 ack released
    9'b0101_11111, // 7  R7 drivers back on
    9'b1101_11101, // 8  R8 cycle starts
    9'b0111_01101, // 9  R3 request mid-cycle, no grant
    9'b0011_01111, // 10 R8 cycle ends
    9'b0111_00111, // 11 R3 grant at boundary
    9'b0011_00111, // 12 R4 dack low blocks claim
    9'b0111_00011, // 13 R4 claim
    9'b0111_10010, // 14 R5
    9'b0111_11010, // 15 R6
    9'b0101_11110, // 16 R7
    9'b0101_11111, // 17 R7
    9'b0111_01111, // 18 R9 request
    9'b0101_10111, // 19 R9 grant, request withdrawn
    9'b0101_11111, // 20 R9 grant dropped
    9'b0111_01111, // 21 R4 request
    9'b0110_00011, // 22 R4 other master acks
    9'b0110_00010, // 23 R4 no claim, R5 float
    9'b0101_10110, // 24 R6 withdrawn
    9'b0101_11110, // 25 R6
    9'b0101_11111  // 26 R7
  };

  task automatic check(string req, logic [4:0] act, logic [4:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s br/bg/back/as/oe act=%b exp=%b", req, act, exp);
    end
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1", {br_n, bg_n, back_n, as_n, oe}, 5'b11111);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1", {br_n, bg_n, back_n, as_n, oe}, 5'b11111);

    for (int i = 0; i < NV; i++) begin
      {own_go, dack_n, pend, ext_n} = VEC[i][8:5];
      @(negedge clk);
      check($sformatf("R2-R9 step %0d", i), {br_n, bg_n, back_n, as_n, oe}, VEC[i][4:0]);
    end

    // R8: long wait for dack keeps the strobe low
    {own_go, dack_n, pend, ext_n} = 4'b1101;
    @(negedge clk);
    own_go = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R8 wait", {br_n, bg_n, back_n, as_n, oe}, 5'b11101);
    end
    dack_n = 1'b0;
    @(negedge clk);
    check("R8 end", {br_n, bg_n, back_n, as_n, oe}, 5'b11111);
    dack_n = 1'b1;

    // R1: reset in the middle of a handoff
    pend = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 pre", {br_n, bg_n, back_n, as_n, oe}, 5'b10010);
    rst_ni = 1'b0;
    #1;
    check("R1 mid", {br_n, bg_n, back_n, as_n, oe}, 5'b11111);
    pend = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 after", {br_n, bg_n, back_n, as_n, oe}, 5'b11111);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule